// File: doc/BRIEF.md
# Memory region permission checker

This block sits in front of a memory and judges each access against four programmable address windows. Every window has a base address, a length counted in 64 KB units, a read permission, a write permission and a flag that marks the window as protected by error-correcting code. For each access presented on the access port, one cycle later the block reports the region that matched, whether the access is allowed, and whether the error-correcting path should be used. Any access that falls outside every window, or that lacks the permission its direction needs, produces a one-cycle violation pulse and the address is captured for later inspection.

Windows, and a 2-bit page-size code used by the error-correcting path, are set through a small configuration port. A write selects an operation and, for window operations, a window index. Readback is combinational on the same select lines. Writes that name a window index outside 0..3, an illegal page size or an undefined operation are dropped and flagged. A single operation loads a ready-to-use default setup for window 0.

Top module: `region_guard`

## Requirements
- R1: Window operations (cfg_op 0 base, 1 length, 2 permissions, 3 ECC flag) accept cfg_idx 0..3 only; a write with cfg_idx 4..7, or any write with cfg_op 6 or 7, changes no state and drives cfg_err high for exactly the next cycle; readback of a window operation with cfg_idx 4..7 returns 0.
- R2: A permission write (cfg_op 2) clears both permissions of the window and then sets write-allowed from cfg_wdata bit 0 and read-allowed from cfg_wdata bit 1; readback returns read-allowed in bit 1 and write-allowed in bit 0.
- R3: The ECC flag (cfg_op 3, cfg_wdata bit 0, readback bit 0) is held per window and is not altered by permission writes, nor are permissions altered by ECC flag writes.
- R4: A page-size write (cfg_op 4) of 256, 512, 1024 or 2048 sets page_code to 0, 1, 2 or 3 respectively, and readback of cfg_op 4 returns the byte value; any other value leaves page_code unchanged and pulses cfg_err.
- R5: A default write (cfg_op 5) sets window 0 to base 0, length 4096, read and write allowed, ECC on, and sets the page size to 512; the other windows keep their settings.
- R6: An access hits a window when base <= address < base + length*65536; when several windows match, the lowest index is reported on rsp_rgn with rsp_hit high; on a miss rsp_hit and rsp_rgn are 0.
- R7: The response appears in the cycle after acc_valid: rsp_ok is high when the access hits and the winning window allows the direction (acc_write 1 needs write-allowed, 0 needs read-allowed); rsp_ecc is high when rsp_ok is high and the winning window has ECC on.
- R8: A miss or a denied access raises viol for one cycle in its response cycle and loads viol_addr with the access address, which then holds until the next violation.
- R9: After reset every window has base 0, length 0, no permissions and ECC off, page_code is 1 (512 bytes), and all response outputs and cfg_err are 0.
- R10: When a configuration write and an access occur in the same cycle, the access is judged on the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation select for write and readback |
| cfg_idx | input | 3 | Window index for window operations |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational readback of the selected field |
| cfg_err | output | 1 | Pulse: previous configuration write was rejected |
| page_code | output | 2 | Current page-size code |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | Access direction, 1 for write |
| acc_addr | input | 32 | Access byte address |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | Access fell inside a window |
| rsp_rgn | output | 2 | Index of the winning window |
| rsp_ok | output | 1 | Access permitted |
| rsp_ecc | output | 1 | Error-correcting path applies |
| viol | output | 1 | One-cycle violation pulse |
| viol_addr | output | 32 | Address of the most recent violation |

## Verification
A configuration write and an access can land on the same clock edge, and the block must then judge the access on the settings that existed before that edge. The bench sets a window to read-only, then in a single cycle both grants it write permission and issues a write access inside it; the response must show a denial with a violation, and an identical access one cycle later must be allowed. A second collision case pairs a rejected configuration write with violations, so that cfg_err and viol rise together and each is judged on its own output.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int RG_NUM       = 4;
    localparam int RG_IDX_W     = 3;
    localparam int RG_SEL_W     = $clog2(RG_NUM);
    localparam int RG_ADDR_W    = 32;
    localparam int RG_SIZE_W    = 16;
    localparam int RG_UNIT_LOG2 = 16;
    localparam int RG_LIM_W     = ((RG_SIZE_W + RG_UNIT_LOG2) > RG_ADDR_W ?
                                   (RG_SIZE_W + RG_UNIT_LOG2) : RG_ADDR_W) + 1;
    localparam int RG_PAGE_N    = 4;
    localparam int RG_PAGE_MIN  = 256;

    typedef enum logic [2:0] {
        OP_BASE = 3'd0,
        OP_LEN  = 3'd1,
        OP_PERM = 3'd2,
        OP_ECC  = 3'd3,
        OP_PAGE = 3'd4,
        OP_DFLT = 3'd5
    } cfg_op_e;

    typedef struct packed {
        logic [RG_ADDR_W-1:0] base;
        logic [RG_SIZE_W-1:0] len;
        logic                 rd;
        logic                 wr;
        logic                 ecc;
    } rgn_t;

    localparam rgn_t RGN_CLEAR = '0;
    localparam rgn_t RGN_DEFAULT = '{
        base: '0,
        len:  RG_SIZE_W'(4096),
        rd:   1'b1,
        wr:   1'b1,
        ecc:  1'b1
    };
    localparam logic [1:0] PAGE_DFLT_CODE = 2'd1;

    // Byte value of one page size code
    function automatic logic [RG_ADDR_W-1:0] page_bytes(input logic [1:0] code);
        return RG_ADDR_W'(RG_PAGE_MIN) << code;
    endfunction

    function automatic logic page_legal(input logic [RG_ADDR_W-1:0] b);
        logic r;
        r = 1'b0;
        for (int k = 0; k < RG_PAGE_N; k++) begin
            if (b == page_bytes(2'(k))) r = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [1:0] page_code_of(input logic [RG_ADDR_W-1:0] b);
        logic [1:0] c;
        c = PAGE_DFLT_CODE;
        for (int k = 0; k < RG_PAGE_N; k++) begin
            if (b == page_bytes(2'(k))) c = 2'(k);
        end
        return c;
    endfunction

    // Exclusive upper bound of a window, one bit wider than any operand
    function automatic logic [RG_LIM_W-1:0] window_end(
        input logic [RG_ADDR_W-1:0] base,
        input logic [RG_SIZE_W-1:0] len
    );
        return RG_LIM_W'(base) + (RG_LIM_W'(len) << RG_UNIT_LOG2);
    endfunction

endpackage

// File: rtl/rgn_cfg_regs.sv
module rgn_cfg_regs
    import rgn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_op,
    input  logic [RG_IDX_W-1:0]  cfg_idx,
    input  logic [RG_ADDR_W-1:0] cfg_wdata,
    output logic [RG_ADDR_W-1:0] cfg_rdata,
    output logic                 cfg_err,
    output logic [1:0]           page_code,
    output rgn_t                 rgns [RG_NUM]
);

    localparam int RGN_BITS = $bits(rgn_t);

    cfg_op_e             op;
    logic                idx_ok;
    logic                win_op;
    logic                bad_wr;
    logic [RG_SEL_W-1:0] sel;
    rgn_t                rgns_q [RG_NUM];
    logic [1:0]          page_q;
    logic                err_q;
    logic [RG_NUM*RGN_BITS-1:0] flat;

    assign op     = cfg_op_e'(cfg_op);
    assign idx_ok = (cfg_idx < RG_IDX_W'(RG_NUM));
    assign win_op = ~cfg_op[2];
    assign sel    = cfg_idx[RG_SEL_W-1:0];

    always_comb begin
        bad_wr = 1'b0;
        if (cfg_wr) begin
            if (win_op && !idx_ok)                            bad_wr = 1'b1;
            if (op == OP_PAGE && !page_legal(cfg_wdata))      bad_wr = 1'b1;
            if (cfg_op > 3'd5)                                bad_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RG_NUM; i++) rgns_q[i] <= RGN_CLEAR;
            page_q <= PAGE_DFLT_CODE;
            err_q  <= 1'b0;
        end else begin
            err_q <= bad_wr;
            if (cfg_wr && !bad_wr) begin
                for (int i = 0; i < RG_NUM; i++) begin
                    if (win_op && cfg_idx == RG_IDX_W'(i)) begin
                        case (op)
                            OP_BASE: rgns_q[i].base <= cfg_wdata;
                            OP_LEN:  rgns_q[i].len  <= cfg_wdata[RG_SIZE_W-1:0];
                            OP_PERM: begin
                                rgns_q[i].wr <= cfg_wdata[0];
                                rgns_q[i].rd <= cfg_wdata[1];
                            end
                            OP_ECC:  rgns_q[i].ecc <= cfg_wdata[0];
                            default: ;
                        endcase
                    end
                end
                if (op == OP_PAGE) page_q <= page_code_of(cfg_wdata);
                if (op == OP_DFLT) begin
                    rgns_q[0] <= RGN_DEFAULT;
                    page_q    <= PAGE_DFLT_CODE;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (op)
            OP_BASE: if (idx_ok) cfg_rdata = rgns_q[sel].base;
            OP_LEN:  if (idx_ok) cfg_rdata = RG_ADDR_W'(rgns_q[sel].len);
            OP_PERM: if (idx_ok) cfg_rdata = RG_ADDR_W'({rgns_q[sel].rd, rgns_q[sel].wr});
            OP_ECC:  if (idx_ok) cfg_rdata = RG_ADDR_W'(rgns_q[sel].ecc);
            OP_PAGE: cfg_rdata = page_bytes(page_q);
            default: cfg_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < RG_NUM; g++) begin : g_out
        assign rgns[g] = rgns_q[g];
        assign flat[g*RGN_BITS +: RGN_BITS] = rgns_q[g];
    end

    assign page_code = page_q;
    assign cfg_err   = err_q;

    // R1
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && win_op && !idx_ok) |=> (cfg_err && $stable(flat)));

    // R1
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_op > 3'd5) |=> (cfg_err && $stable(flat) && $stable(page_q)));

    // R4
    bad_page_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && op == OP_PAGE && !page_legal(cfg_wdata)) |=> (cfg_err && $stable(page_code)));

    // R4
    good_page_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && op == OP_PAGE && page_legal(cfg_wdata)) |=>
            (!cfg_err && page_bytes(page_code) == $past(cfg_wdata)));

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_pkg::*;
(
    input  logic [RG_ADDR_W-1:0] base,
    input  logic [RG_SIZE_W-1:0] len,
    input  logic [RG_ADDR_W-1:0] addr,
    output logic                 hit
);

    logic [RG_LIM_W-1:0] lo;
    logic [RG_LIM_W-1:0] hi;
    logic [RG_LIM_W-1:0] a;

    assign lo  = RG_LIM_W'(base);
    assign hi  = window_end(base, len);
    assign a   = RG_LIM_W'(addr);
    assign hit = (a >= lo) && (a < hi);

endmodule

// File: rtl/rgn_judge.sv
module rgn_judge
    import rgn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [RG_ADDR_W-1:0] acc_addr,
    input  logic [RG_NUM-1:0]    hits,
    input  logic [RG_NUM-1:0]    rd_ok,
    input  logic [RG_NUM-1:0]    wr_ok,
    input  logic [RG_NUM-1:0]    ecc_on,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [RG_SEL_W-1:0]  rsp_rgn,
    output logic                 rsp_ok,
    output logic                 rsp_ecc,
    output logic                 viol,
    output logic [RG_ADDR_W-1:0] viol_addr
);

    logic [RG_SEL_W-1:0] win;
    logic                any;
    logic                allow;
    logic                ecc_use;

    // Lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = RG_NUM - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win = RG_SEL_W'(i);
                any = 1'b1;
            end
        end
    end

    assign allow   = any && (acc_write ? wr_ok[win] : rd_ok[win]);
    assign ecc_use = allow && ecc_on[win];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rgn   <= '0;
            rsp_ok    <= 1'b0;
            rsp_ecc   <= 1'b0;
            viol      <= 1'b0;
            viol_addr <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_hit   <= acc_valid && any;
            rsp_rgn   <= (acc_valid && any) ? win : '0;
            rsp_ok    <= acc_valid && allow;
            rsp_ecc   <= acc_valid && ecc_use;
            viol      <= acc_valid && !allow;
            if (acc_valid && !allow) viol_addr <= acc_addr;
        end
    end

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_valid));

    // R7
    ecc_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ecc |-> (rsp_ok && rsp_hit));

    // R6
    ok_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> rsp_hit);

    // R8
    viol_addr_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> (viol_addr == $past(acc_addr)));

    // R8
    viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && !acc_valid) |=> !viol);

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_op,
    input  logic [RG_IDX_W-1:0]  cfg_idx,
    input  logic [RG_ADDR_W-1:0] cfg_wdata,
    output logic [RG_ADDR_W-1:0] cfg_rdata,
    output logic                 cfg_err,
    output logic [1:0]           page_code,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [RG_ADDR_W-1:0] acc_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [RG_SEL_W-1:0]  rsp_rgn,
    output logic                 rsp_ok,
    output logic                 rsp_ecc,
    output logic                 viol,
    output logic [RG_ADDR_W-1:0] viol_addr
);

    rgn_t              rgns [RG_NUM];
    logic [RG_NUM-1:0] hits;
    logic [RG_NUM-1:0] rd_ok;
    logic [RG_NUM-1:0] wr_ok;
    logic [RG_NUM-1:0] ecc_on;

    rgn_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_op    (cfg_op),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .page_code (page_code),
        .rgns      (rgns)
    );

    for (genvar g = 0; g < RG_NUM; g++) begin : g_win
        rgn_match u_match (
            .base (rgns[g].base),
            .len  (rgns[g].len),
            .addr (acc_addr),
            .hit  (hits[g])
        );
        assign rd_ok[g]  = rgns[g].rd;
        assign wr_ok[g]  = rgns[g].wr;
        assign ecc_on[g] = rgns[g].ecc;
    end

    rgn_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .hits      (hits),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .ecc_on    (ecc_on),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_rgn   (rsp_rgn),
        .rsp_ok    (rsp_ok),
        .rsp_ecc   (rsp_ecc),
        .viol      (viol),
        .viol_addr (viol_addr)
    );

endmodule

// File: tb/tb_region_guard.sv
module tb_region_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_op = 3'd0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic [1:0]  page_code;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = 32'd0;
    logic        rsp_valid, rsp_hit, rsp_ok, rsp_ecc, viol;
    logic [1:0]  rsp_rgn;
    logic [31:0] viol_addr;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic        err_seen;
    logic [31:0] rbv;

    always #2 clk = ~clk;

    region_guard dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .page_code(page_code),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rgn(rsp_rgn),
        .rsp_ok(rsp_ok), .rsp_ecc(rsp_ecc), .viol(viol), .viol_addr(viol_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        hit;
        logic [1:0]  rgn;
        logic        ok;
        logic        ecc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0000, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
        '{32'h0002_FFFF, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1},
        '{32'h0003_0000, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0},
        '{32'h0003_0000, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
        '{32'h0005_FFFF, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0},
        '{32'h0006_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{32'h0000_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{32'h0010_0000, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1},
        '{32'h0010_0004, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
        '{32'h0010_FFFF, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] op, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        err_seen = cfg_err;
        cfg_wr = 1'b0;
    endtask

    task automatic readback(input logic [2:0] op, input logic [2:0] idx);
        @(negedge clk);
        cfg_op = op; cfg_idx = idx;
        #1 rbv = cfg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 page_code", 32'(page_code), 32'd1);
        check("R9 rsp_ok", 32'(rsp_ok), 0);
        check("R9 viol", 32'(viol), 0);
        check("R9 cfg_err", 32'(cfg_err), 0);
        readback(3'd4, 3'd0); check("R9 page readback", rbv, 32'd512);
        readback(3'd2, 3'd0); check("R9 perm r0", rbv, 0);
        readback(3'd3, 3'd3); check("R9 ecc r3", rbv, 0);
        readback(3'd1, 3'd2); check("R9 len r2", rbv, 0);
        access(32'h0, 1'b0);
        check("R9 no window after reset", 32'({rsp_hit, rsp_ok, viol}), 32'b001);

        // R1 illegal index and opcode
        cfg_write(3'd0, 3'd5, 32'h1234_0000);
        check("R1 bad index err", 32'(err_seen), 1);
        @(negedge clk); check("R1 err one cycle", 32'(cfg_err), 0);
        readback(3'd0, 3'd5); check("R1 bad index readback", rbv, 0);
        readback(3'd0, 3'd0); check("R1 r0 base untouched", rbv, 0);
        cfg_write(3'd6, 3'd0, 32'hFFFF_FFFF);
        check("R1 bad op err", 32'(err_seen), 1);
        readback(3'd4, 3'd0); check("R1 page untouched", rbv, 32'd512);

        // setup for table
        cfg_write(3'd0, 3'd0, 32'h0001_0000); cfg_write(3'd1, 3'd0, 32'd2);
        cfg_write(3'd2, 3'd0, 32'd3);         cfg_write(3'd3, 3'd0, 32'd1);
        cfg_write(3'd0, 3'd1, 32'h0002_0000); cfg_write(3'd1, 3'd1, 32'd4);
        cfg_write(3'd2, 3'd1, 32'd2);         cfg_write(3'd3, 3'd1, 32'd0);
        cfg_write(3'd0, 3'd2, 32'h0010_0000); cfg_write(3'd1, 3'd2, 32'd1);
        cfg_write(3'd2, 3'd2, 32'd1);         cfg_write(3'd3, 3'd2, 32'd1);

        // R6 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].wr);
            check("R7 rsp_valid", 32'(rsp_valid), 1);
            check("R6 hit", 32'(rsp_hit), 32'(VECS[i].hit));
            check("R6 region", 32'(rsp_rgn), 32'(VECS[i].rgn));
            check("R7 ok", 32'(rsp_ok), 32'(VECS[i].ok));
            check("R7 ecc", 32'(rsp_ecc), 32'(VECS[i].ecc));
            check("R8 viol", 32'(viol), 32'(!VECS[i].ok));
            if (!VECS[i].ok) check("R8 viol_addr", viol_addr, VECS[i].addr);
        end

        // R8 pulse length and hold
        access(32'h0006_0000, 1'b0);
        @(negedge clk);
        check("R8 viol one cycle", 32'(viol), 0);
        access(32'h0001_0000, 1'b0);
        check("R8 no viol on allowed", 32'(viol), 0);
        check("R8 viol_addr holds", viol_addr, 32'h0006_0000);

        // R2 permission replace
        cfg_write(3'd2, 3'd1, 32'd3);
        readback(3'd2, 3'd1); check("R2 perm both", rbv, 32'd3);
        cfg_write(3'd2, 3'd1, 32'd1);
        readback(3'd2, 3'd1); check("R2 read cleared", rbv, 32'd1);
        access(32'h0003_0000, 1'b0);
        check("R2 read denied", 32'(rsp_ok), 0);
        cfg_write(3'd2, 3'd1, 32'd2);

        // R3 independence
        cfg_write(3'd3, 3'd0, 32'd0);
        readback(3'd2, 3'd0); check("R3 perm kept", rbv, 32'd3);
        access(32'h0001_0000, 1'b0);
        check("R3 ecc off ok", 32'({rsp_ok, rsp_ecc}), 32'b10);
        cfg_write(3'd3, 3'd0, 32'd1);
        cfg_write(3'd2, 3'd0, 32'd0);
        readback(3'd3, 3'd0); check("R3 ecc kept", rbv, 32'd1);
        cfg_write(3'd2, 3'd0, 32'd3);

        // R4 page codes
        cfg_write(3'd4, 3'd0, 32'd1024);
        check("R4 1024 code", 32'(page_code), 32'd2);
        check("R4 1024 no err", 32'(err_seen), 0);
        readback(3'd4, 3'd0); check("R4 1024 readback", rbv, 32'd1024);
        cfg_write(3'd4, 3'd0, 32'd768);
        check("R4 bad size err", 32'(err_seen), 1);
        check("R4 bad size kept", 32'(page_code), 32'd2);
        cfg_write(3'd4, 3'd0, 32'd2048); check("R4 2048 code", 32'(page_code), 32'd3);
        cfg_write(3'd4, 3'd0, 32'd256);  check("R4 256 code", 32'(page_code), 32'd0);

        // R10 write and access in the same cycle
        @(negedge clk);
        cfg_wr = 1'b1; cfg_op = 3'd2; cfg_idx = 3'd1; cfg_wdata = 32'd3;
        acc_valid = 1'b1; acc_addr = 32'h0003_0000; acc_write = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        check("R10 old config used", 32'({rsp_ok, viol}), 32'b01);
        access(32'h0003_0000, 1'b1);
        check("R10 new config next", 32'(rsp_ok), 1);

        // R1 and R8 together: rejected write with a violating access
        @(negedge clk);
        cfg_wr = 1'b1; cfg_op = 3'd7; cfg_idx = 3'd0; cfg_wdata = 32'd0;
        acc_valid = 1'b1; acc_addr = 32'h0070_0000; acc_write = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        check("R1 err with access", 32'(cfg_err), 1);
        check("R8 viol with err", 32'(viol), 1);
        check("R8 addr with err", viol_addr, 32'h0070_0000);

        // R5 default setup
        cfg_write(3'd5, 3'd0, 32'd0);
        readback(3'd0, 3'd0); check("R5 base", rbv, 0);
        readback(3'd1, 3'd0); check("R5 len", rbv, 32'd4096);
        readback(3'd2, 3'd0); check("R5 perm", rbv, 32'd3);
        readback(3'd3, 3'd0); check("R5 ecc", rbv, 32'd1);
        readback(3'd4, 3'd0); check("R5 page", rbv, 32'd512);
        readback(3'd0, 3'd1); check("R5 r1 kept", rbv, 32'h0002_0000);
        access(32'h0FFF_FFFF, 1'b1);
        check("R5 top of window", 32'({rsp_hit, rsp_rgn, rsp_ok, rsp_ecc}), 32'b10011);
        access(32'h1000_0000, 1'b0);
        check("R5 past window", 32'({rsp_hit, viol}), 32'b01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule